// File: doc/BRIEF.md
# Counter/LFSR Pattern Source

This block produces a stream of test data words for built-in self-test logic. One state register holds the pattern. A run-time mode bit picks how the register steps. In counting mode it adds one each step. In scrambled mode it works as a Fibonacci linear feedback shift register: it shifts toward its top bit and takes in a new low bit, which is the XOR of the tapped state bits. The register steps only in cycles where the step-enable input is high. The output word is the register itself, or its low bits when the output is narrower.

The block has two named modes, carried in an enumerated type: `MODE_COUNT` and `MODE_LFSR`. These are the two update rules. Changing the mode never clears the register: on the next enabled step, the newly chosen rule is applied to whatever value the register holds. If the register is all zero when a scrambled step is taken, it loads 1 instead of shifting, so it can never lock up.

By default the state and output are both 23 bits wide. The feedback taps sit at state bits 22 and 17. A synchronous, active-high reset clears the state to zero.

Top module: `patsrc_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the state and `pattern_out` are all zero.
- R2: In a cycle where `step_en` is low, the state keeps its value in either mode, so `pattern_out` stays the same.
- R3: In counting mode (`rnd_mode` = 0), an enabled step loads state + 1, wrapping modulo 2^STATE_W. Starting from reset, the outputs are 0, 1, 2, … with no value skipped.
- R4: In scrambled mode (`rnd_mode` = 1), an enabled step from a nonzero state loads {state[STATE_W-2:0], fb}. Here fb is the XOR of the state bits chosen by TAP_MASK, which by default are bits 22 and 17.
- R5: In scrambled mode, an enabled step from the all-zero state loads 1.
- R6: `pattern_out` equals the low OUT_W bits of the state. By default both widths are 23 bits, so the output is the whole state.
- R7: Changing `rnd_mode` leaves the state unchanged. The next enabled step applies the newly selected rule to the present state.
- R8: In scrambled mode, starting from reset with `step_en` held high, 1024 consecutive outputs contain no repeated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Step enable; the state advances only when this is high |
| rnd_mode | input | 1 | Mode select: 0 = counting, 1 = LFSR |
| pattern_out | output | OUT_W | Current pattern word (low bits of the state) |

## Verification
The output is the state register, so any wrong state shows at `pattern_out` in the cycle straight after the faulty edge. No pipeline hides it.

A wrong tap or a misplaced feedback bit does not show until a tapped bit first becomes one. Starting from reset in scrambled mode, that takes 18 steps. For this reason the LFSR run is checked word by word against an independent model for 1024 steps.

An increment error, or a mode switch that disturbs the state, shows on the first step after the stimulus that triggers it. A register that steps while `step_en` is low shows in the first stalled cycle.

// File: rtl/patsrc_pkg.sv
package patsrc_pkg;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_LFSR  = 1'b1
    } patsrc_mode_e;

endpackage

// File: rtl/patsrc_count_step.sv
module patsrc_count_step #(
    parameter int STATE_W = 23
) (
    input  logic [STATE_W-1:0] cur_state,
    output logic [STATE_W-1:0] nxt_state
);
    localparam logic [STATE_W-1:0] ONE = STATE_W'(1);

    always_comb begin
        nxt_state = cur_state + ONE;
    end
endmodule

// File: rtl/patsrc_lfsr_step.sv
module patsrc_lfsr_step #(
    parameter int                  STATE_W  = 23,
    parameter logic [STATE_W-1:0]  TAP_MASK = STATE_W'((1 << 17) | (1 << 22))
) (
    input  logic [STATE_W-1:0] cur_state,
    output logic [STATE_W-1:0] nxt_state
);
    localparam logic [STATE_W-1:0] SEED = STATE_W'(1);

    logic fb_bit;

    always_comb begin
        fb_bit = ^(cur_state & TAP_MASK);
        if (cur_state == '0) begin
            nxt_state = SEED;
        end else begin
            nxt_state = {cur_state[STATE_W-2:0], fb_bit};
        end
    end
endmodule

// File: rtl/patsrc_gen.sv
module patsrc_gen
    import patsrc_pkg::*;
#(
    parameter int                  OUT_W    = 23,
    parameter int                  STATE_W  = 23,
    parameter logic [STATE_W-1:0]  TAP_MASK = STATE_W'((1 << 17) | (1 << 22))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             rnd_mode,
    output logic [OUT_W-1:0] pattern_out
);
    localparam logic [STATE_W-1:0] ONE = STATE_W'(1);

    patsrc_mode_e       mode_sel;
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] cnt_next;
    logic [STATE_W-1:0] lfsr_next;
    logic [STATE_W-1:0] state_d;

    assign mode_sel = patsrc_mode_e'(rnd_mode);

    patsrc_count_step #(.STATE_W(STATE_W)) u_count (
        .cur_state (state_q),
        .nxt_state (cnt_next)
    );

    patsrc_lfsr_step #(.STATE_W(STATE_W), .TAP_MASK(TAP_MASK)) u_lfsr (
        .cur_state (state_q),
        .nxt_state (lfsr_next)
    );

    // Select the update rule for the currently chosen mode
    always_comb begin
        state_d = state_q;
        if (step_en) begin
            unique case (mode_sel)
                MODE_COUNT: state_d = cnt_next;
                MODE_LFSR:  state_d = lfsr_next;
                default:    state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Output: low bits of the state, zero-extended if the output is wider
    generate
        if (OUT_W <= STATE_W) begin : g_out_narrow
            always_comb pattern_out = state_q[OUT_W-1:0];
        end else begin : g_out_wide
            always_comb pattern_out = {{(OUT_W-STATE_W){1'b0}}, state_q};
        end
    endgenerate

    // Assertions
    always @(posedge clk) begin
        if (!rst && $past(rst)) begin
            assert_reset_zero_R1: assert (state_q == '0);
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(state_q));

    assert_count_R3: assert property (@(posedge clk) disable iff (rst)
        (step_en && !rnd_mode) |=> (state_q == $past(state_q) + ONE));

    assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (step_en && rnd_mode && state_q != '0)
        |=> (state_q[STATE_W-1:1] == $past(state_q[STATE_W-2:0])));

    assert_unlock_R5: assert property (@(posedge clk) disable iff (rst)
        (step_en && rnd_mode && state_q == '0) |=> (state_q == ONE));

    assert_no_lockup_R5: assert property (@(posedge clk) disable iff (rst)
        (step_en && rnd_mode) |=> (state_q != '0));

    assert_out_low_R6: assert property (@(posedge clk) disable iff (rst)
        pattern_out[0] == state_q[0]);

endmodule

// File: tb/patsrc_gen_tb.sv
module patsrc_gen_tb;

    localparam int W = 23;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         step_en = 1'b0;
    logic         rnd_mode = 1'b0;
    logic [W-1:0] pattern_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    patsrc_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .step_en     (step_en),
        .rnd_mode    (rnd_mode),
        .pattern_out (pattern_out)
    );

    // {step_en, rnd_mode, expected output after the step}, starting from reset
    localparam int NV = 10;
    localparam logic [W+1:0] VEC [NV] = '{
        {1'b1, 1'b0, 23'd1},
        {1'b1, 1'b0, 23'd2},
        {1'b0, 1'b0, 23'd2},
        {1'b1, 1'b0, 23'd3},
        {1'b1, 1'b1, 23'd6},
        {1'b1, 1'b1, 23'd12},
        {1'b0, 1'b1, 23'd12},
        {1'b1, 1'b0, 23'd13},
        {1'b1, 1'b1, 23'd26},
        {1'b1, 1'b0, 23'd27}
    };

    function automatic logic [W-1:0] lfsr_model(input logic [W-1:0] s);
        if (s == '0) return 23'd1;
        return {s[W-2:0], s[22] ^ s[17]};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset held", pattern_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", pattern_out, '0);
    endtask

    task automatic step(input logic e, input logic m);
        step_en = e;
        rnd_mode = m;
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] model;
        bit seen [logic [W-1:0]];
        int dups;

        @(negedge clk);
        do_reset();

        // Vector walk: R2 stall, R3 count, R4 shift, R7 mode switch, R6 output
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][W+1], VEC[i][W]);
            check("R3/R4/R2/R7/R6 vector", pattern_out, VEC[i][W-1:0]);
        end

        // Scrambled run from zero: R5 first step, R4 each step, R8 uniqueness
        do_reset();
        model = '0;
        dups = 0;
        for (int i = 0; i < 1024; i++) begin
            step(1'b1, 1'b1);
            model = lfsr_model(model);
            if (i == 0) check("R5 zero unlock", pattern_out, 23'd1);
            else        check("R4 lfsr step", pattern_out, model);
            if (seen.exists(pattern_out)) dups++;
            seen[pattern_out] = 1'b1;
        end
        checks++;
        if (dups != 0) begin
            failures++;
            $display("FAIL R8 repeats actual=%0d expected=0", dups);
        end

        // R2 stall in scrambled mode
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1);
            check("R2 hold lfsr", pattern_out, model);
        end

        // R7 switch to counting from an lfsr state, then back
        step(1'b0, 1'b0);
        check("R7 switch no change", pattern_out, model);
        step(1'b1, 1'b0);
        model = model + 23'd1;
        check("R7 count after lfsr", pattern_out, model);
        step(1'b1, 1'b1);
        model = lfsr_model(model);
        check("R7 lfsr after count", pattern_out, model);

        // R3 counting run of 1024 from reset
        do_reset();
        for (int i = 1; i <= 1024; i++) begin
            step(1'b1, 1'b0);
            check("R3 count", pattern_out, W'(i));
        end

        // R1 reset in the middle of a run
        rst = 1'b1;
        step_en = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", pattern_out, '0);
        @(negedge clk);
        check("R1 reset with enable", pattern_out, '0);
        rst = 1'b0;
        step_en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule